// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block takes a single-cycle exception request and, one clock later, presents the address of the handler to fetch from. The request carries a kind code, the faulting PC, a delay-slot flag, a faulting virtual address and a coprocessor number. At the same clock edge the block rewrites the exception-related state it owns:
- the exception-level, error-level and boot-vector status bits;
- the cause code, branch-delay bit and coprocessor field;
- the saved return PC and the saved error return PC;
- the bad-address, page-table-context and translation-tag registers.

The current status bits, the interrupt-vector bit, the exception base and the address-space ID are inputs. The unit is driven by the pipeline's trap logic, and the handler PC output steers the fetch stage.

The handler address is chosen as follows:
- The vector base is either the fixed boot location or the programmable exception base.
- An offset is added to the base. It depends on whether the fault is a translation refill taken outside exception level, on the interrupt-vector bit, and on whether the event is a cache error.

The return PC is saved only when the processor was not already at exception level. For a fault in a branch delay slot, the saved PC is backed up to the branch.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows:
  - `pc_valid_o`, `debug_mode_o` and `st_exl_o` are 0.
  - `st_erl_o` and `st_bev_o` are 1.
  - `handler_pc_o`, `exc_code_o`, `cause_bd_o`, `cause_ce_o`, `epc_o`, `error_epc_o` and `badvaddr_o` are 0.
  - `entryhi_o` and the low 23 bits of `context_o` are 0.
- R2: An accepted request (`req_valid_o` high with a defined kind) sets the registered outputs in the next cycle: `handler_pc_o` holds the handler address and `pc_valid_o` is high for exactly that one cycle. Kind codes 21 to 31 are ignored. They raise no `pc_valid_o` and change no output.
- R3: Each kind code maps to a cause code, which is written into `exc_code_o`. The kind codes and their cause codes are:
  - 0 interrupt → 0
  - 1 TLB modify → 1
  - 2 TLB miss on load → 2
  - 3 TLB invalid on load → 2
  - 4 TLB miss on store → 3
  - 5 TLB invalid on store → 3
  - 6 address error on load → 4
  - 7 address error on store → 5
  - 8 instruction bus error → 6
  - 9 data bus error → 7
  - 10 syscall → 8
  - 11 break → 9
  - 12 reserved instruction → 10
  - 13 coprocessor unusable → 11
  - 14 overflow → 12
  - 15 trap → 13
  - 16 floating point → 15
  - 17 cache error → 30
  - 18 NMI, 19 soft reset and 20 debug leave `exc_code_o` unchanged.
- R4: For kinds 0 to 17 the vector base is 0xBFC00200 when `st_bev_i` is 1. When `st_bev_i` is 0 the base is `ebase_i` with bits [9:0] cleared.
- R5: The offset added to the base is 0x180. The exception is an interrupt taken while `cause_iv_i` is 1, which uses 0x200.
- R6: TLB-miss kinds (2 and 4) use offset 0x000 when `st_exl_i` is 0 and 0x180 when it is 1. TLB-invalid kinds (3 and 5) always use 0x180.
- R7: For kinds 0 to 17 with `st_exl_i` at 0:
  - `epc_o` becomes `req_pc_i` minus 4 when `req_delay_i` is 1, and `req_pc_i` otherwise.
  - `cause_bd_o` becomes `req_delay_i`.

  With `st_exl_i` at 1, `epc_o` and `cause_bd_o` are unchanged. In both cases `st_exl_o` becomes 1, and `st_bev_o` and `st_erl_o` copy `st_bev_i` and `st_erl_i`.
- R8: A cache error (kind 17) uses offset 0x100 when `st_bev_i` is 1 and 0x20000100 when it is 0.
- R9: NMI (kind 18) and soft reset (kind 19) do the following:
  - set `st_erl_o` and `st_bev_o` to 1, and copy `st_exl_i` into `st_exl_o`;
  - save the resume PC (minus 4 in a delay slot) in `error_epc_o`;
  - set the handler to 0xBFC00000.

  They leave `epc_o` and `exc_code_o` unchanged.
- R10: Debug (kind 20) does only two things: it sets `debug_mode_o` to 1 and the handler to 0xBFC00480. `epc_o`, `exc_code_o` and the status outputs do not change.
- R11: TLB and address-error kinds (1 to 7) update three registers:
  - `badvaddr_o` becomes `req_vaddr_i`.
  - Bits [22:0] of `context_o` become (`req_vaddr_i` >> 9) & 0x7FFFF0, while bits [31:23] show `ptbase_i`.
  - `entryhi_o` becomes `req_vaddr_i` with bits [12:0] cleared, ORed with the 8-bit `asid_i`.

  Other kinds leave these three registers unchanged.
- R12: Coprocessor unusable (kind 13) writes `req_cop_i` into the 2-bit `cause_ce_o`. Other kinds leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | One-cycle exception request |
| req_kind_i | input | 5 | Exception kind code |
| req_pc_i | input | 32 | PC of the faulting instruction |
| req_delay_i | input | 1 | Fault lies in a branch delay slot |
| req_vaddr_i | input | 32 | Faulting virtual address |
| req_cop_i | input | 2 | Coprocessor number for coprocessor-unusable |
| st_bev_i | input | 1 | Current boot-vector status bit |
| st_exl_i | input | 1 | Current exception-level status bit |
| st_erl_i | input | 1 | Current error-level status bit |
| cause_iv_i | input | 1 | Interrupt-vector select bit |
| ebase_i | input | 32 | Exception base register |
| asid_i | input | 8 | Current address-space ID |
| ptbase_i | input | 9 | Page-table base, the upper context bits |
| handler_pc_o | output | 32 | Handler fetch address |
| pc_valid_o | output | 1 | Handler address is new this cycle |
| debug_mode_o | output | 1 | Debug mode entered |
| st_bev_o | output | 1 | Updated boot-vector bit |
| st_exl_o | output | 1 | Updated exception-level bit |
| st_erl_o | output | 1 | Updated error-level bit |
| exc_code_o | output | 5 | Cause code |
| cause_bd_o | output | 1 | Branch-delay bit |
| cause_ce_o | output | 2 | Coprocessor field of the cause register |
| epc_o | output | 32 | Saved exception return PC |
| error_epc_o | output | 32 | Saved error return PC |
| badvaddr_o | output | 32 | Faulting virtual address |
| context_o | output | 32 | Page-table context |
| entryhi_o | output | 32 | Translation tag with ASID |

## Verification
Every result of this block is due exactly one rising edge after the request is sampled: the handler PC and the valid pulse, the cause, the return PCs, the status bits and the translation registers. The bench drives each request on a falling edge and holds it for one full cycle. It then samples all outputs at the next falling edge, when the capturing edge has passed and no new edge is pending. One falling edge later it confirms that the valid pulse has dropped. For the cases where something must be left alone, the bench records the affected outputs before the stimulus and compares them after the capturing edge.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry unit.
// Assumes a 32-bit address space and an 8-bit address-space ID.
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int ASID_W  = 8;
    localparam int CODE_W  = 5;
    localparam int KIND_W  = 5;
    localparam int PTB_W   = 9;

    localparam logic [XLEN-1:0] BOOT_GEN_BASE = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] BOOT_ERR_PC   = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BOOT_DBG_PC   = 32'hBFC0_0480;
    localparam logic [XLEN-1:0] OFS_GENERAL   = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_IRQ_VEC   = 32'h0000_0200;
    localparam logic [XLEN-1:0] OFS_REFILL    = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFS_CERR_BOOT = 32'h0000_0100;
    localparam logic [XLEN-1:0] OFS_CERR_RUN  = 32'h2000_0100;
    localparam logic [XLEN-1:0] BASE_ALIGN    = 32'hFFFF_FC00;

    typedef enum logic [KIND_W-1:0] {
        K_IRQ       = 5'd0,
        K_TLB_MOD   = 5'd1,
        K_MISS_LD   = 5'd2,
        K_INV_LD    = 5'd3,
        K_MISS_ST   = 5'd4,
        K_INV_ST    = 5'd5,
        K_ADDR_LD   = 5'd6,
        K_ADDR_ST   = 5'd7,
        K_IBUS      = 5'd8,
        K_DBUS      = 5'd9,
        K_SYSCALL   = 5'd10,
        K_BREAK     = 5'd11,
        K_RSVD      = 5'd12,
        K_COP_OFF   = 5'd13,
        K_OVF       = 5'd14,
        K_TRAP      = 5'd15,
        K_FPE       = 5'd16,
        K_CACHE_ERR = 5'd17,
        K_NMI       = 5'd18,
        K_SOFT_RST  = 5'd19,
        K_DEBUG     = 5'd20
    } exc_kind_e;

    // Decoded view of one request kind
    typedef struct packed {
        logic              known;
        logic              general;
        logic              err_lvl;
        logic              debug;
        logic              mmu;
        logic              refill;
        logic              irq;
        logic              cache;
        logic              cop;
        logic [CODE_W-1:0] code;
    } exc_class_t;

endpackage

// File: rtl/exc_classify.sv
// Decodes an exception kind into its entry class and cause code.
// Assumes kind codes above 20 are undefined; they decode with known = 0.
module exc_classify
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] kind_i,
    output exc_class_t        cls_o
);

    // Map kind to class flags and cause code
    always_comb begin
        cls_o = '0;
        cls_o.known   = 1'b1;
        cls_o.general = 1'b1;
        case (kind_i)
            K_IRQ:       begin cls_o.code = 5'd0; cls_o.irq = 1'b1; end
            K_TLB_MOD:   begin cls_o.code = 5'd1; cls_o.mmu = 1'b1; end
            K_MISS_LD:   begin cls_o.code = 5'd2; cls_o.mmu = 1'b1; cls_o.refill = 1'b1; end
            K_INV_LD:    begin cls_o.code = 5'd2; cls_o.mmu = 1'b1; end
            K_MISS_ST:   begin cls_o.code = 5'd3; cls_o.mmu = 1'b1; cls_o.refill = 1'b1; end
            K_INV_ST:    begin cls_o.code = 5'd3; cls_o.mmu = 1'b1; end
            K_ADDR_LD:   begin cls_o.code = 5'd4; cls_o.mmu = 1'b1; end
            K_ADDR_ST:   begin cls_o.code = 5'd5; cls_o.mmu = 1'b1; end
            K_IBUS:      cls_o.code = 5'd6;
            K_DBUS:      cls_o.code = 5'd7;
            K_SYSCALL:   cls_o.code = 5'd8;
            K_BREAK:     cls_o.code = 5'd9;
            K_RSVD:      cls_o.code = 5'd10;
            K_COP_OFF:   begin cls_o.code = 5'd11; cls_o.cop = 1'b1; end
            K_OVF:       cls_o.code = 5'd12;
            K_TRAP:      cls_o.code = 5'd13;
            K_FPE:       cls_o.code = 5'd15;
            K_CACHE_ERR: begin cls_o.code = 5'd30; cls_o.cache = 1'b1; end
            K_NMI, K_SOFT_RST: begin
                cls_o.general = 1'b0;
                cls_o.err_lvl = 1'b1;
            end
            K_DEBUG: begin
                cls_o.general = 1'b0;
                cls_o.debug   = 1'b1;
            end
            default: begin
                cls_o.known   = 1'b0;
                cls_o.general = 1'b0;
            end
        endcase
    end

    // R2
    // A defined kind falls into exactly one entry path.
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls_o.known |-> $onehot({cls_o.general, cls_o.err_lvl, cls_o.debug}));

endmodule

// File: rtl/exc_vector_sel.sv
// Computes the handler address for a decoded exception.
// Assumes the base register's low ten bits are ignored.
module exc_vector_sel
    import exc_pkg::*;
(
    input  exc_class_t      cls_i,
    input  logic            bev_i,
    input  logic            exl_i,
    input  logic            iv_i,
    input  logic [XLEN-1:0] ebase_i,
    output logic [XLEN-1:0] vec_pc_o
);

    logic [XLEN-1:0] gen_base;
    logic [XLEN-1:0] gen_ofs;

    // Pick the base for general exceptions
    always_comb begin
        gen_base = bev_i ? BOOT_GEN_BASE : (ebase_i & BASE_ALIGN);
    end

    // Pick the offset by refill, interrupt vector and cache-error cases
    always_comb begin
        if (cls_i.refill && !exl_i)      gen_ofs = OFS_REFILL;
        else if (cls_i.irq && iv_i)      gen_ofs = OFS_IRQ_VEC;
        else if (cls_i.cache)            gen_ofs = bev_i ? OFS_CERR_BOOT : OFS_CERR_RUN;
        else                             gen_ofs = OFS_GENERAL;
    end

    // Final handler address by entry path
    always_comb begin
        if (cls_i.debug)        vec_pc_o = BOOT_DBG_PC;
        else if (cls_i.err_lvl) vec_pc_o = BOOT_ERR_PC;
        else                    vec_pc_o = gen_base + gen_ofs;
    end

endmodule

// File: rtl/exc_mmu_capture.sv
// Holds the fault address, page-table context field and translation tag.
// Assumes 4 KiB page pairs: the tag keeps address bits above bit 12.
module exc_mmu_capture
    import exc_pkg::*;
#(
    parameter int PAIR_SHIFT = 13,
    parameter int CTX_W      = 23
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [XLEN-1:0]   vaddr_i,
    input  logic [ASID_W-1:0] asid_i,
    output logic [XLEN-1:0]   badvaddr_o,
    output logic [CTX_W-1:0]  ctx_field_o,
    output logic [XLEN-1:0]   entryhi_o
);

    localparam int VPN2_W   = XLEN - PAIR_SHIFT;
    localparam int CTX_LOW  = CTX_W - VPN2_W;
    localparam int TAG_ZERO = PAIR_SHIFT - ASID_W;

    // Capture the translation registers on an MMU fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            badvaddr_o  <= '0;
            ctx_field_o <= '0;
            entryhi_o   <= '0;
        end else if (cap_i) begin
            badvaddr_o  <= vaddr_i;
            ctx_field_o <= {vaddr_i[XLEN-1:PAIR_SHIFT], {CTX_LOW{1'b0}}};
            entryhi_o   <= {vaddr_i[XLEN-1:PAIR_SHIFT], {TAG_ZERO{1'b0}}, asid_i};
        end
    end

    // R11
    // Without a capture request the fault address holds.
    badvaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(badvaddr_o));

endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry and vector unit: on a one-cycle request it updates
// status, cause, return PCs and translation registers, and presents the
// handler PC one cycle later. Assumes requests are not back-pressured.
module exc_entry_unit
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [KIND_W-1:0] req_kind_i,
    input  logic [XLEN-1:0]   req_pc_i,
    input  logic              req_delay_i,
    input  logic [XLEN-1:0]   req_vaddr_i,
    input  logic [1:0]        req_cop_i,
    input  logic              st_bev_i,
    input  logic              st_exl_i,
    input  logic              st_erl_i,
    input  logic              cause_iv_i,
    input  logic [XLEN-1:0]   ebase_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [PTB_W-1:0]  ptbase_i,
    output logic [XLEN-1:0]   handler_pc_o,
    output logic              pc_valid_o,
    output logic              debug_mode_o,
    output logic              st_bev_o,
    output logic              st_exl_o,
    output logic              st_erl_o,
    output logic [CODE_W-1:0] exc_code_o,
    output logic              cause_bd_o,
    output logic [1:0]        cause_ce_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   error_epc_o,
    output logic [XLEN-1:0]   badvaddr_o,
    output logic [XLEN-1:0]   context_o,
    output logic [XLEN-1:0]   entryhi_o
);

    localparam int CTX_W = XLEN - PTB_W;

    exc_class_t      cls;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] resume_pc;
    logic [CTX_W-1:0] ctx_field;
    logic            acc;

    exc_classify u_classify (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (req_kind_i),
        .cls_o  (cls)
    );

    exc_vector_sel u_vector (
        .cls_i    (cls),
        .bev_i    (st_bev_i),
        .exl_i    (st_exl_i),
        .iv_i     (cause_iv_i),
        .ebase_i  (ebase_i),
        .vec_pc_o (vec_pc)
    );

    exc_mmu_capture #(
        .PAIR_SHIFT (13),
        .CTX_W      (CTX_W)
    ) u_mmu (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (acc && cls.mmu),
        .vaddr_i     (req_vaddr_i),
        .asid_i      (asid_i),
        .badvaddr_o  (badvaddr_o),
        .ctx_field_o (ctx_field),
        .entryhi_o   (entryhi_o)
    );

    // Accept only defined kinds; resume PC backs up over a branch
    always_comb begin
        acc       = req_valid_i && cls.known;
        resume_pc = req_delay_i ? (req_pc_i - 32'd4) : req_pc_i;
        context_o = {ptbase_i, ctx_field};
    end

    // Entry state registers, written once per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_pc_o <= '0;
            pc_valid_o   <= 1'b0;
            debug_mode_o <= 1'b0;
            st_bev_o     <= 1'b1;
            st_exl_o     <= 1'b0;
            st_erl_o     <= 1'b1;
            exc_code_o   <= '0;
            cause_bd_o   <= 1'b0;
            cause_ce_o   <= '0;
            epc_o        <= '0;
            error_epc_o  <= '0;
        end else begin
            pc_valid_o <= acc;
            if (acc) begin
                handler_pc_o <= vec_pc;
                if (cls.debug) begin
                    debug_mode_o <= 1'b1;
                end
                if (cls.err_lvl) begin
                    st_erl_o    <= 1'b1;
                    st_bev_o    <= 1'b1;
                    st_exl_o    <= st_exl_i;
                    error_epc_o <= resume_pc;
                end
                if (cls.general) begin
                    exc_code_o <= cls.code;
                    st_exl_o   <= 1'b1;
                    st_bev_o   <= st_bev_i;
                    st_erl_o   <= st_erl_i;
                    if (!st_exl_i) begin
                        epc_o      <= resume_pc;
                        cause_bd_o <= req_delay_i;
                    end
                end
                if (cls.cop) begin
                    cause_ce_o <= req_cop_i;
                end
            end
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cls.known) |=> pc_valid_o);

    // R7
    epc_kept_at_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cls.general && st_exl_i) |=> ($stable(epc_o) && $stable(cause_bd_o)));

    // R9
    err_level_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cls.err_lvl) |=> (st_erl_o && st_bev_o && handler_pc_o == BOOT_ERR_PC));

    // R10
    debug_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cls.debug) |=> (debug_mode_o && $stable(exc_code_o) && $stable(epc_o)));

    // R4
    boot_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cls.general && !cls.cache && st_bev_i) |=> (handler_pc_o[31:12] == 20'hBFC00));

endmodule

// File: tb/exc_entry_unit_tb_top.sv
// Directed bench for the exception entry unit.
module exc_entry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_kind = '0;
    logic [31:0] req_pc = '0;
    logic        req_delay = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_cop = '0;
    logic        bev = 1'b1, exl = 1'b0, erl = 1'b0, iv = 1'b0;
    logic [31:0] ebase = 32'h8000_0000;
    logic [7:0]  asid = 8'h00;
    logic [8:0]  ptbase = 9'h000;

    logic [31:0] handler_pc, epc, error_epc, badvaddr, context_v, entryhi;
    logic        pc_valid, debug_mode, bev_o, exl_o, erl_o, bd;
    logic [4:0]  code;
    logic [1:0]  ce;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_pc_i(req_pc),
        .req_delay_i(req_delay), .req_vaddr_i(req_vaddr), .req_cop_i(req_cop),
        .st_bev_i(bev), .st_exl_i(exl), .st_erl_i(erl), .cause_iv_i(iv),
        .ebase_i(ebase), .asid_i(asid), .ptbase_i(ptbase),
        .handler_pc_o(handler_pc), .pc_valid_o(pc_valid), .debug_mode_o(debug_mode),
        .st_bev_o(bev_o), .st_exl_o(exl_o), .st_erl_o(erl_o),
        .exc_code_o(code), .cause_bd_o(bd), .cause_ce_o(ce),
        .epc_o(epc), .error_epc_o(error_epc), .badvaddr_o(badvaddr),
        .context_o(context_v), .entryhi_o(entryhi)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected under 20000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Issue one request for one cycle; returns at the falling edge after capture
    task automatic fire(input logic [4:0] k, input logic [31:0] pc, input logic dly,
                        input logic [31:0] va, input logic [1:0] cp);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_pc = pc; req_delay = dly;
        req_vaddr = va; req_cop = cp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_ctx(input logic [8:0] pb, input logic [31:0] va);
        return {pb, 23'd0} | ((va >> 9) & 32'h007F_FFF0);
    endfunction

    task automatic t_reset();
        chk("R1 pc_valid", {31'd0, pc_valid}, 32'd0);
        chk("R1 handler", handler_pc, 32'd0);
        chk("R1 status bev/exl/erl", {29'd0, bev_o, exl_o, erl_o}, 32'd5);
        chk("R1 debug", {31'd0, debug_mode}, 32'd0);
        chk("R1 epc", epc, 32'd0);
        chk("R1 code", {27'd0, code}, 32'd0);
        chk("R1 badvaddr", badvaddr, 32'd0);
        chk("R1 entryhi", entryhi, 32'd0);
    endtask

    task automatic t_syscall();
        bev = 0; exl = 0; erl = 0; ebase = 32'h8000_0000;
        fire(5'd10, 32'h0040_0100, 1'b0, 32'h0, 2'd0);
        chk("R2 valid pulse", {31'd0, pc_valid}, 32'd1);
        chk("R5 syscall handler", handler_pc, 32'h8000_0180);
        chk("R3 syscall code", {27'd0, code}, 32'd8);
        chk("R7 epc", epc, 32'h0040_0100);
        chk("R7 bd clear", {31'd0, bd}, 32'd0);
        chk("R7 exl set, bev/erl copied", {29'd0, bev_o, exl_o, erl_o}, 32'd2);
        @(negedge clk);
        chk("R2 valid one cycle", {31'd0, pc_valid}, 32'd0);
    endtask

    task automatic t_irq();
        bev = 0; exl = 0; ebase = 32'h8000_0000;
        iv = 1;
        fire(5'd0, 32'h0000_2000, 1'b0, 32'h0, 2'd0);
        chk("R5 irq iv=1", handler_pc, 32'h8000_0200);
        chk("R3 irq code", {27'd0, code}, 32'd0);
        iv = 0;
        fire(5'd0, 32'h0000_2000, 1'b0, 32'h0, 2'd0);
        chk("R5 irq iv=0", handler_pc, 32'h8000_0180);
    endtask

    task automatic t_ebase_align();
        bev = 0; exl = 0; ebase = 32'h8000_1234;
        fire(5'd11, 32'h0000_3000, 1'b0, 32'h0, 2'd0);
        chk("R4 ebase low bits cleared", handler_pc, 32'h8000_1180);
        chk("R3 break code", {27'd0, code}, 32'd9);
        ebase = 32'h8000_0000;
    endtask

    task automatic t_tlb_miss();
        logic [31:0] va = 32'h1234_5678;
        bev = 1; exl = 0; asid = 8'h5A; ptbase = 9'h1AB;
        fire(5'd2, 32'h0000_4000, 1'b0, va, 2'd0);
        chk("R6 miss exl=0 offset 0", handler_pc, 32'hBFC0_0200);
        chk("R3 miss load code", {27'd0, code}, 32'd2);
        chk("R11 badvaddr", badvaddr, va);
        chk("R11 context", context_v, exp_ctx(9'h1AB, va));
        chk("R11 entryhi", entryhi, (va & 32'hFFFF_E000) | 32'h5A);
    endtask

    task automatic t_tlb_exl();
        logic [31:0] epc_before;
        logic        bd_before;
        bev = 1; exl = 1;
        epc_before = epc; bd_before = bd;
        fire(5'd4, 32'h0000_5000, 1'b1, 32'hC000_2000, 2'd0);
        chk("R6 miss exl=1 offset 0x180", handler_pc, 32'hBFC0_0380);
        chk("R3 miss store code", {27'd0, code}, 32'd3);
        chk("R7 epc kept at exl", epc, epc_before);
        chk("R7 bd kept at exl", {31'd0, bd}, {31'd0, bd_before});
        chk("R7 exl stays set", {31'd0, exl_o}, 32'd1);
        exl = 0;
        fire(5'd3, 32'h0000_5000, 1'b0, 32'h0000_7000, 2'd0);
        chk("R6 invalid offset 0x180", handler_pc, 32'hBFC0_0380);
        chk("R3 invalid load code", {27'd0, code}, 32'd2);
    endtask

    task automatic t_delay_slot();
        bev = 0; exl = 0;
        fire(5'd14, 32'h0000_1000, 1'b1, 32'h0, 2'd0);
        chk("R7 delay epc", epc, 32'h0000_0FFC);
        chk("R7 delay bd", {31'd0, bd}, 32'd1);
        chk("R3 overflow code", {27'd0, code}, 32'd12);
    endtask

    task automatic t_cop_unusable();
        logic [31:0] bva_before;
        bev = 0; exl = 0;
        bva_before = badvaddr;
        fire(5'd13, 32'h0000_6000, 1'b0, 32'hDEAD_0000, 2'd2);
        chk("R12 ce field", {30'd0, ce}, 32'd2);
        chk("R3 cop code", {27'd0, code}, 32'd11);
        chk("R11 badvaddr untouched", badvaddr, bva_before);
        fire(5'd16, 32'h0000_6000, 1'b0, 32'h0, 2'd1);
        chk("R12 ce kept", {30'd0, ce}, 32'd2);
        chk("R3 fpe code", {27'd0, code}, 32'd15);
    endtask

    task automatic t_cache_err();
        bev = 1; exl = 0;
        fire(5'd17, 32'h0000_7000, 1'b0, 32'h0, 2'd0);
        chk("R8 cache err bev=1", handler_pc, 32'hBFC0_0300);
        chk("R3 cache code", {27'd0, code}, 32'd30);
        bev = 0; ebase = 32'h8000_0400;
        fire(5'd17, 32'h0000_7000, 1'b0, 32'h0, 2'd0);
        chk("R8 cache err bev=0", handler_pc, 32'hA000_0500);
        ebase = 32'h8000_0000;
    endtask

    task automatic t_nmi();
        logic [31:0] epc_before;
        logic [4:0]  code_before;
        bev = 0; exl = 0; erl = 0;
        epc_before = epc; code_before = code;
        fire(5'd18, 32'h0000_8008, 1'b1, 32'h0, 2'd0);
        chk("R9 nmi handler", handler_pc, 32'hBFC0_0000);
        chk("R9 error epc", error_epc, 32'h0000_8004);
        chk("R9 erl/bev set, exl copied", {29'd0, bev_o, exl_o, erl_o}, 32'd5);
        chk("R9 epc kept", epc, epc_before);
        chk("R9 code kept", {27'd0, code}, {27'd0, code_before});
        fire(5'd19, 32'h0000_9000, 1'b0, 32'h0, 2'd0);
        chk("R9 soft reset error epc", error_epc, 32'h0000_9000);
    endtask

    task automatic t_debug();
        logic [31:0] epc_before;
        logic [4:0]  code_before;
        logic [2:0]  st_before;
        epc_before = epc; code_before = code; st_before = {bev_o, exl_o, erl_o};
        bev = 0; exl = 0; erl = 0;
        fire(5'd20, 32'h0000_A000, 1'b0, 32'h0, 2'd0);
        chk("R10 debug handler", handler_pc, 32'hBFC0_0480);
        chk("R10 debug flag", {31'd0, debug_mode}, 32'd1);
        chk("R10 epc kept", epc, epc_before);
        chk("R10 code kept", {27'd0, code}, {27'd0, code_before});
        chk("R10 status kept", {29'd0, bev_o, exl_o, erl_o}, {29'd0, st_before});
    endtask

    task automatic t_undefined();
        logic [31:0] pc_before, epc_before;
        logic [4:0]  code_before;
        pc_before = handler_pc; epc_before = epc; code_before = code;
        bev = 0; exl = 0;
        fire(5'd25, 32'h0000_B000, 1'b0, 32'h0, 2'd0);
        chk("R2 undefined kind no valid", {31'd0, pc_valid}, 32'd0);
        chk("R2 undefined kind handler kept", handler_pc, pc_before);
        chk("R2 undefined kind epc kept", epc, epc_before);
        chk("R2 undefined kind code kept", {27'd0, code}, {27'd0, code_before});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_syscall();
        t_irq();
        t_ebase_align();
        t_tlb_miss();
        t_tlb_exl();
        t_delay_slot();
        t_cop_unusable();
        t_cache_err();
        t_nmi();
        t_debug();
        t_undefined();
        finish_run();
    end

endmodule